// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This block sits between a 32-bit register file and a byte-addressed data memory port. On each accepted request it adds the base register value to the sign-extended 16-bit offset to form the effective address. For byte, halfword and word accesses it drives one memory beat in the same cycle. A double access drives two consecutive beats, moving an even/odd register pair. Lanes are big-endian: the byte at address offset 0 travels on bus bits 31:24.

On stores the unit produces byte enables and copies the low byte or low halfword of the source register onto every lane it could land in. On loads it picks the addressed lane out of the read word and extends it with the sign bit or with zeros. The result goes out on a registered writeback port one cycle later. Writebacks aimed at register index 0 are dropped. Misaligned halfword, word and double requests make no memory access and raise a one-cycle error flag.

The memory port uses a combinational read: `mem_rdata` must reflect `mem_addr` in the same cycle that `mem_en` is high. A write takes effect at the clock edge that ends the beat.

Top module: `lsu_align_unit`

## Requirements
- R1: In the cycle a request is accepted (`req_valid` and `req_ready` high) and is neither misaligned nor an unknown code, `mem_en` is high and `mem_addr` equals `req_base` plus `req_imm` sign-extended to 32 bits, with wraparound.
- R2: Byte loads return the lane selected by address bits 1:0, where offset 0 is bus bits 31:24 and offset 3 is bits 7:0. Code 0 (signed byte) copies bit 7 of that byte into the upper 24 bits. Code 1 (unsigned byte) fills them with zeros.
- R3: Halfword loads return bus bits 31:16 at offset 0 and bits 15:0 at offset 2. Code 2 (signed halfword) sign-extends from bit 15. Code 3 (unsigned halfword) zero-extends.
- R4: A word load (code 4) returns the whole read word unchanged.
- R5: `mem_be` bit 3 governs bus bits 31:24 and bit 0 governs bits 7:0. A byte store (code 6) at offset k sets only bit 3-k. A halfword store (code 7) sets 4'b1100 at offset 0 and 4'b0011 at offset 2. A word store (code 8) sets 4'b1111. During load beats `mem_we` is low and `mem_be` is 4'b0000.
- R6: Store data is `req_st_data` replicated. A byte store carries its bits 7:0 on all four lanes. A halfword store carries its bits 15:0 in both halves. A word store carries the full value.
- R7: A halfword access with address bit 0 set is misaligned. A word or double access with address bits 1:0 non-zero is misaligned. A misaligned request keeps `mem_en` low, so no write occurs. It pulses `err` high in the following cycle and produces no writeback.
- R8: A double access uses two beats. Beat 1 is at address A and uses register `{req_rd[4:1],0}` with store data `req_st_data`. Beat 2 follows in the next cycle at A+4 and uses register `{req_rd[4:1],1}` with store data `req_st_pair`. During beat 2 `req_ready` is low and `req_valid` is ignored. Code 5 is the double load and code 9 is the double store.
- R9: A load beat whose destination index is 0 never raises `wb_en`.
- R10: Each load beat to a non-zero index raises `wb_en` exactly one cycle after the beat, with `wb_idx` set to the destination index and `wb_data` set to the formatted value. Store beats raise no writeback.
- R11: Codes 10 to 15 are unknown. They cause no memory access, no writeback and no error.
- R12: After synchronous reset, with no request pending, `req_ready` is high and `mem_en`, `wb_en` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_op | input | 4 | Access code (see R2 to R8, R11) |
| req_base | input | 32 | Base register value |
| req_imm | input | 16 | Signed address offset |
| req_rd | input | 5 | Data register index |
| req_st_data | input | 32 | Store value of the data register (even register for doubles) |
| req_st_pair | input | 32 | Store value of the odd register for double stores |
| mem_en | output | 1 | Memory beat active |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Byte address of the beat |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data for `mem_addr`, same cycle |
| wb_en | output | 1 | Register write strobe |
| wb_idx | output | 5 | Register index to write |
| wb_data | output | 32 | Register write value |
| err | output | 1 | Misaligned request flag |

## Verification
The hardest case to reach is the second beat of a double access. The cycle in which the unit ignores a new request must coincide with that beat writing the odd half. Register index 0 makes this worse, because the even half of the pair must be dropped while the odd half still lands in register 1.

Directed sequences cover these cases. A double store is followed by double loads that read the data back into pairs based at index 0 and index 7. The bench also holds `req_valid` high during the second beat to confirm it is ignored. Misaligned stores are followed by aligned word reads that prove memory was left untouched. A seeded random mix of all codes, small bases and signed offsets then drives misalignment, wraparound and lane selection through the same checks.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int XLEN  = 32;
    localparam int IMM_W = 16;
    localparam int REG_W = 5;
    localparam int LANES = XLEN / 8;
    localparam int OFS_W = $clog2(LANES);

    typedef enum logic [3:0] {
        OP_LB  = 4'd0,
        OP_LBU = 4'd1,
        OP_LH  = 4'd2,
        OP_LHU = 4'd3,
        OP_LW  = 4'd4,
        OP_LD  = 4'd5,
        OP_SB  = 4'd6,
        OP_SH  = 4'd7,
        OP_SW  = 4'd8,
        OP_SD  = 4'd9
    } lsu_op_e;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2
    } size_e;

    typedef struct packed {
        logic  is_load;
        logic  is_store;
        logic  is_dbl;
        logic  sign;
        size_e size;
    } dec_t;

    typedef struct packed {
        logic [XLEN-1:0]  addr;
        logic [REG_W-1:0] idx;
        logic [XLEN-1:0]  data;
        logic             is_load;
        logic             is_store;
        logic             sign;
        size_e            size;
    } beat_t;

    function automatic dec_t decode(logic [3:0] op);
        dec_t d;
        d = '0;
        case (op)
            OP_LB:  begin d.is_load = 1'b1; d.sign = 1'b1; d.size = SZ_B; end
            OP_LBU: begin d.is_load = 1'b1; d.size = SZ_B; end
            OP_LH:  begin d.is_load = 1'b1; d.sign = 1'b1; d.size = SZ_H; end
            OP_LHU: begin d.is_load = 1'b1; d.size = SZ_H; end
            OP_LW:  begin d.is_load = 1'b1; d.size = SZ_W; end
            OP_LD:  begin d.is_load = 1'b1; d.is_dbl = 1'b1; d.size = SZ_W; end
            OP_SB:  begin d.is_store = 1'b1; d.size = SZ_B; end
            OP_SH:  begin d.is_store = 1'b1; d.size = SZ_H; end
            OP_SW:  begin d.is_store = 1'b1; d.size = SZ_W; end
            OP_SD:  begin d.is_store = 1'b1; d.is_dbl = 1'b1; d.size = SZ_W; end
            default: d = '0;
        endcase
        return d;
    endfunction

    function automatic logic misaligned(size_e sz, logic [OFS_W-1:0] ofs);
        case (sz)
            SZ_H:    return ofs[0];
            SZ_W:    return |ofs;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
    import lsu_pkg::*;
(
    input  logic [XLEN-1:0]  base_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic [XLEN-1:0]  ea_o
);

    logic [XLEN-1:0] imm_ext;

    assign imm_ext = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    assign ea_o    = base_i + imm_ext;

endmodule

// File: rtl/lsu_store_fmt.sv
module lsu_store_fmt
    import lsu_pkg::*;
(
    input  size_e            size_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic [XLEN-1:0]  data_i,
    output logic [LANES-1:0] be_o,
    output logic [XLEN-1:0]  wdata_o
);

    // lane i carries bus bits [XLEN-1-8i -: 8] and enable bit LANES-1-i
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int HI = XLEN - 1 - 8 * i;
        logic [7:0] half_byte;

        assign half_byte = (i % 2 == 0) ? data_i[15:8] : data_i[7:0];

        assign be_o[LANES-1-i] =
            (size_i == SZ_B) ? (ofs_i == OFS_W'(i)) :
            (size_i == SZ_H) ? (ofs_i[OFS_W-1:1] == (OFS_W-1)'(i / 2)) :
                               1'b1;

        assign wdata_o[HI -: 8] =
            (size_i == SZ_B) ? data_i[7:0] :
            (size_i == SZ_H) ? half_byte :
                               data_i[HI -: 8];
    end

endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt
    import lsu_pkg::*;
(
    input  size_e            size_i,
    input  logic             sign_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic [XLEN-1:0]  rdata_i,
    output logic [XLEN-1:0]  value_o
);

    logic [XLEN-1:0] shifted;

    // move the addressed lane to the top of the word
    assign shifted = rdata_i << {ofs_i, 3'b000};

    always_comb begin
        case (size_i)
            SZ_B:    value_o = {{(XLEN-8){sign_i & shifted[XLEN-1]}}, shifted[XLEN-1 -: 8]};
            SZ_H:    value_o = {{(XLEN-16){sign_i & shifted[XLEN-1]}}, shifted[XLEN-1 -: 16]};
            default: value_o = shifted;
        endcase
    end

endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
    import lsu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [3:0]       req_op,
    input  logic [XLEN-1:0]  req_base,
    input  logic [IMM_W-1:0] req_imm,
    input  logic [REG_W-1:0] req_rd,
    input  logic [XLEN-1:0]  req_st_data,
    input  logic [XLEN-1:0]  req_st_pair,
    output logic             mem_en,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [LANES-1:0] mem_be,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             wb_en,
    output logic [REG_W-1:0] wb_idx,
    output logic [XLEN-1:0]  wb_data,
    output logic             err
);

    dec_t             dec;
    logic [XLEN-1:0]  ea;
    logic             mis;
    logic             accept;
    logic             memop;
    logic             go;
    logic             busy_q;
    beat_t            first;
    beat_t            nxt_q;
    beat_t            cur;
    logic [LANES-1:0] be_raw;
    logic [XLEN-1:0]  ld_val;

    assign dec    = decode(req_op);
    assign memop  = dec.is_load | dec.is_store;
    assign accept = req_valid & ~busy_q;

    lsu_addr_gen u_addr (
        .base_i (req_base),
        .imm_i  (req_imm),
        .ea_o   (ea)
    );

    assign mis = misaligned(dec.size, ea[OFS_W-1:0]);

    always_comb begin
        first.addr     = ea;
        first.idx      = dec.is_dbl ? {req_rd[REG_W-1:1], 1'b0} : req_rd;
        first.data     = req_st_data;
        first.is_load  = dec.is_load;
        first.is_store = dec.is_store;
        first.sign     = dec.sign;
        first.size     = dec.size;
    end

    assign go  = busy_q | (accept & memop & ~mis);
    assign cur = busy_q ? nxt_q : first;

    lsu_store_fmt u_store (
        .size_i  (cur.size),
        .ofs_i   (cur.addr[OFS_W-1:0]),
        .data_i  (cur.data),
        .be_o    (be_raw),
        .wdata_o (mem_wdata)
    );

    lsu_load_fmt u_load (
        .size_i  (cur.size),
        .sign_i  (cur.sign),
        .ofs_i   (cur.addr[OFS_W-1:0]),
        .rdata_i (mem_rdata),
        .value_o (ld_val)
    );

    assign mem_en    = go;
    assign mem_we    = go & cur.is_store;
    assign mem_addr  = cur.addr;
    assign mem_be    = mem_we ? be_raw : '0;
    assign req_ready = ~busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            nxt_q   <= '0;
            wb_en   <= 1'b0;
            wb_idx  <= '0;
            wb_data <= '0;
            err     <= 1'b0;
        end else begin
            wb_en   <= go & cur.is_load & (cur.idx != '0);
            wb_idx  <= cur.idx;
            wb_data <= ld_val;
            err     <= accept & memop & mis;
            if (busy_q) begin
                busy_q <= 1'b0;
            end else if (accept && memop && !mis && dec.is_dbl) begin
                busy_q         <= 1'b1;
                nxt_q.addr     <= ea + XLEN'(LANES);
                nxt_q.idx      <= {req_rd[REG_W-1:1], 1'b1};
                nxt_q.data     <= req_st_pair;
                nxt_q.is_load  <= dec.is_load;
                nxt_q.is_store <= dec.is_store;
                nxt_q.sign     <= 1'b0;
                nxt_q.size     <= SZ_W;
            end
        end
    end

endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
    import lsu_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [3:0]       req_op,
    input logic [XLEN-1:0]  req_base,
    input logic [IMM_W-1:0] req_imm,
    input logic             mem_en,
    input logic             mem_we,
    input logic [XLEN-1:0]  mem_addr,
    input logic [LANES-1:0] mem_be,
    input logic             wb_en,
    input logic [REG_W-1:0] wb_idx,
    input logic             err
);

    logic            acc;
    logic [XLEN-1:0] ea_c;
    logic            is_half;
    logic            is_wordish;
    logic            is_pair;
    logic            known;
    logic            bad_align;

    assign acc        = req_valid && req_ready;
    assign ea_c       = req_base + {{(XLEN-IMM_W){req_imm[IMM_W-1]}}, req_imm};
    assign is_half    = (req_op == 4'd2) || (req_op == 4'd3) || (req_op == 4'd7);
    assign is_pair    = (req_op == 4'd5) || (req_op == 4'd9);
    assign is_wordish = (req_op == 4'd4) || (req_op == 4'd8) || is_pair;
    assign known      = (req_op <= 4'd9);
    assign bad_align  = (is_half && ea_c[0]) || (is_wordish && (ea_c[1:0] != 2'b00));

    a_r1_addr_sum: assert property (@(posedge clk) disable iff (rst)
        acc && known && !bad_align |-> mem_en && (mem_addr == ea_c));

    a_r5_store_be_shape: assert property (@(posedge clk) disable iff (rst)
        mem_en && mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                              || $countones(mem_be) == 4));

    a_r5_load_no_be: assert property (@(posedge clk) disable iff (rst)
        !mem_we |-> (mem_be == '0));

    a_r7_no_access: assert property (@(posedge clk) disable iff (rst)
        acc && known && bad_align |-> !mem_en);

    a_r7_flag_next: assert property (@(posedge clk) disable iff (rst)
        acc && known && bad_align |=> err && !wb_en);

    a_r8_second_beat: assert property (@(posedge clk) disable iff (rst)
        acc && is_pair && !bad_align |=> !req_ready && mem_en
                                          && (mem_addr == $past(mem_addr) + XLEN'(LANES)));

    a_r8_ready_back: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> req_ready);

    a_r9_no_zero_write: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (wb_idx != '0));

    a_r11_unknown_idle: assert property (@(posedge clk) disable iff (rst)
        acc && !known |-> !mem_en);

endmodule

bind lsu_align_unit lsu_align_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_base  (req_base),
    .req_imm   (req_imm),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .wb_en     (wb_en),
    .wb_idx    (wb_idx),
    .err       (err)
);

// File: tb/test_lsu_align_unit.sv
`timescale 1ns/1ps
module test_lsu_align_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_op = 4'd0;
    logic [31:0] req_base = '0;
    logic [15:0] req_imm = '0;
    logic [4:0]  req_rd = '0;
    logic [31:0] req_st_data = '0;
    logic [31:0] req_st_pair = '0;
    logic        mem_en;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        wb_en;
    logic [4:0]  wb_idx;
    logic [31:0] wb_data;
    logic        err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] mem [16];
    logic [31:0] ref_mem [16];

    always #2.5 clk = ~clk;

    lsu_align_unit i_lsu_align_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_base(req_base), .req_imm(req_imm), .req_rd(req_rd),
        .req_st_data(req_st_data), .req_st_pair(req_st_pair),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .err(err)
    );

    function automatic logic [31:0] init_word(int i);
        return (32'(i) * 32'h0101_0101) ^ 32'h80F0_7F0F;
    endfunction

    // memory model: combinational read, byte-enabled write at the clock edge
    assign mem_rdata = mem[mem_addr[5:2]];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) mem[i] <= init_word(i);
        end else if (mem_en && mem_we) begin
            for (int k = 0; k < 4; k++)
                if (mem_be[3-k]) mem[mem_addr[5:2]][31-8*k -: 8] <= mem_wdata[31-8*k -: 8];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int size_of(logic [3:0] op);
        case (op)
            4'd0, 4'd1, 4'd6: return 1;
            4'd2, 4'd3, 4'd7: return 2;
            4'd4, 4'd5, 4'd8, 4'd9: return 4;
            default: return 0;
        endcase
    endfunction

    // checks one active beat at the current sample point; returns the expected load value
    task automatic chk_beat(input logic [31:0] a, input bit st, input int sz, input bit sgn,
                            input logic [31:0] d, output logic [31:0] ld);
        logic [31:0] w;
        logic [3:0]  be;
        logic [31:0] wd;
        logic [15:0] h;
        logic [7:0]  b;
        int o;
        o = int'(a[1:0]);
        w = ref_mem[a[5:2]];
        ld = '0;
        chk(mem_en === 1'b1, "R1", 32'(mem_en), 32'd1);
        chk(mem_addr === a, "R1", mem_addr, a);
        chk(mem_we === st, "R5", 32'(mem_we), 32'(st));
        if (st) begin
            if (sz == 1) begin
                be = 4'b1000 >> o;
                wd = {4{d[7:0]}};
            end else if (sz == 2) begin
                be = (o == 0) ? 4'b1100 : 4'b0011;
                wd = {2{d[15:0]}};
            end else begin
                be = 4'b1111;
                wd = d;
            end
            chk(mem_be === be, "R5", 32'(mem_be), 32'(be));
            for (int k = 0; k < 4; k++)
                if (be[3-k]) chk(mem_wdata[31-8*k -: 8] === wd[31-8*k -: 8], "R6", mem_wdata, wd);
            for (int k = 0; k < 4; k++)
                if (be[3-k]) ref_mem[a[5:2]][31-8*k -: 8] = wd[31-8*k -: 8];
        end else begin
            chk(mem_be === 4'b0000, "R5", 32'(mem_be), 32'd0);
            if (sz == 4) begin
                ld = w;
            end else if (sz == 2) begin
                h = (o == 0) ? w[31:16] : w[15:0];
                ld = sgn ? {{16{h[15]}}, h} : {16'h0, h};
            end else begin
                b = 8'((w >> (8 * (3 - o))) & 32'hFF);
                ld = sgn ? {{24{b[7]}}, b} : {24'h0, b};
            end
        end
    endtask

    task automatic chk_wb(input bit was_load, input logic [4:0] idx, input logic [31:0] ld,
                          input string req);
        if (!was_load) begin
            chk(wb_en === 1'b0, "R10", 32'(wb_en), 32'd0);
        end else if (idx == 5'd0) begin
            chk(wb_en === 1'b0, "R9", 32'(wb_en), 32'd0);
        end else begin
            chk(wb_en === 1'b1, "R10", 32'(wb_en), 32'd1);
            chk(wb_idx === idx, "R10", 32'(wb_idx), 32'(idx));
            chk(wb_data === ld, req, wb_data, ld);
        end
    endtask

    task automatic run_op(input logic [3:0] op, input logic [31:0] base, input logic [15:0] imm,
                          input logic [4:0] rd, input logic [31:0] d0, input logic [31:0] d1);
        logic [31:0] ea;
        logic [31:0] ld0;
        logic [31:0] ld1;
        logic [4:0]  i0;
        int sz;
        bit known, st, sgn, dbl, mis, ld;
        string tag;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_base = base; req_imm = imm; req_rd = rd;
        req_st_data = d0; req_st_pair = d1;
        #1;
        ea    = base + {{16{imm[15]}}, imm};
        sz    = size_of(op);
        known = (op <= 4'd9);
        st    = (op >= 4'd6) && known;
        ld    = (op <= 4'd5);
        sgn   = (op == 4'd0) || (op == 4'd2);
        dbl   = (op == 4'd5) || (op == 4'd9);
        mis   = (sz == 2 && ea[0]) || (sz == 4 && ea[1:0] != 2'b00);
        if (!known || mis) begin
            chk(mem_en === 1'b0, known ? "R7" : "R11", 32'(mem_en), 32'd0);
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            chk(err === known, known ? "R7" : "R11", 32'(err), 32'(known));
            chk(wb_en === 1'b0, known ? "R7" : "R11", 32'(wb_en), 32'd0);
            return;
        end
        i0 = dbl ? {rd[4:1], 1'b0} : rd;
        chk_beat(ea, st, sz, sgn, d0, ld0);
        @(negedge clk);
        // request still asserted in the odd beat of a double: it must be ignored (R8)
        if (!dbl) req_valid = 1'b0;
        #1;
        tag = dbl ? "R8" : (sz == 1) ? "R2" : (sz == 2) ? "R3" : "R4";
        chk(err === 1'b0, "R7", 32'(err), 32'd0);
        chk_wb(ld, i0, ld0, tag);
        if (dbl) begin
            chk(req_ready === 1'b0, "R8", 32'(req_ready), 32'd0);
            chk_beat(ea + 32'd4, st, 4, 1'b0, d1, ld1);
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            chk_wb(ld, {rd[4:1], 1'b1}, ld1, "R8");
            chk(req_ready === 1'b1, "R8", 32'(req_ready), 32'd1);
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) ref_mem[i] = init_word(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R12: idle state after reset
        chk(req_ready === 1'b1, "R12", 32'(req_ready), 32'd1);
        chk(mem_en === 1'b0, "R12", 32'(mem_en), 32'd0);
        chk(wb_en === 1'b0, "R12", 32'(wb_en), 32'd0);
        chk(err === 1'b0, "R12", 32'(err), 32'd0);

        // directed: word store then every byte and halfword lane (R2, R3, R4)
        run_op(4'd8, 32'h10, 16'h0, 5'd3, 32'h80FF_7F01, 32'h0);
        for (int k = 0; k < 4; k++) run_op(4'd0, 32'h10, 16'(k), 5'd5, 0, 0);
        for (int k = 0; k < 4; k++) run_op(4'd1, 32'h10, 16'(k), 5'd6, 0, 0);
        run_op(4'd8, 32'h18, 16'h0, 5'd3, 32'h7FFF_8001, 32'h0);
        run_op(4'd2, 32'h18, 16'h0, 5'd7, 0, 0);
        run_op(4'd2, 32'h18, 16'h2, 5'd7, 0, 0);
        run_op(4'd3, 32'h18, 16'h2, 5'd8, 0, 0);
        run_op(4'd4, 32'h14, 16'hFFFC, 5'd9, 0, 0);     // negative offset (R1)

        // byte and halfword stores with replication (R5, R6)
        for (int k = 0; k < 4; k++) run_op(4'd6, 32'h20, 16'(k), 5'd2, 32'h1234_56A0 + 32'(k), 0);
        run_op(4'd7, 32'h24, 16'h2, 5'd2, 32'hDEAD_BEEF, 0);
        run_op(4'd7, 32'h24, 16'h0, 5'd2, 32'h0BAD_C0DE, 0);
        run_op(4'd4, 32'h20, 16'h0, 5'd4, 0, 0);
        run_op(4'd4, 32'h24, 16'h0, 5'd4, 0, 0);

        // misaligned requests leave memory untouched (R7)
        run_op(4'd2, 32'h11, 16'h0, 5'd4, 0, 0);
        run_op(4'd4, 32'h12, 16'h0, 5'd4, 0, 0);
        run_op(4'd8, 32'h13, 16'h0, 5'd4, 32'hFFFF_FFFF, 0);
        run_op(4'd9, 32'h2E, 16'h0, 5'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_op(4'd4, 32'h10, 16'h0, 5'd4, 0, 0);
        run_op(4'd4, 32'h2C, 16'h0, 5'd4, 0, 0);

        // register zero (R9) and double pairs (R8)
        run_op(4'd4, 32'h10, 16'h0, 5'd0, 0, 0);
        run_op(4'd9, 32'h30, 16'h0, 5'd6, 32'hAAAA_5555, 32'h1357_9BDF);
        run_op(4'd5, 32'h30, 16'h0, 5'd0, 0, 0);
        run_op(4'd5, 32'h30, 16'h0, 5'd7, 0, 0);

        // unknown codes (R11)
        run_op(4'd10, 32'h10, 16'h0, 5'd3, 0, 0);
        run_op(4'd15, 32'h10, 16'h0, 5'd3, 32'hFFFF_FFFF, 0);

        // seeded random mix
        void'($urandom(32'd2024));
        for (int n = 0; n < 400; n++) begin
            logic [3:0]  op;
            logic [31:0] base;
            logic [15:0] imm;
            op   = 4'($urandom_range(0, 10));
            base = 32'($urandom_range(0, 63));
            imm  = 16'($urandom_range(0, 31)) - 16'd16;
            run_op(op, base, imm, 5'($urandom), $urandom, $urandom);
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule